// File: doc/BRIEF.md
# Completion Buffer and Deferred Store Queue

This block is the back end of an out-of-order pipeline. The reorder buffer hands it up to two finished instructions per cycle, in program order. They wait in a circular completion buffer until retirement. Each cycle the two oldest entries are examined. An entry that produces a register result drives one of two register-file write lanes. A store is moved into a store queue instead of going to memory at once.

The store queue gives priority to loads for the single data-memory port. It sends its oldest store to memory only in a cycle where the load path does not request the port. While stores wait, a load address can be compared against every queued store. The data of the youngest matching store is returned with a hit flag, so loads never observe stale memory.

Retirement is strictly in order. A store that finds the store queue full blocks itself and everything younger. Older non-store entries still retire. When the completion buffer cannot take another pair, the block drops its ready signal toward the reorder buffer.

Top module: `cmpl_retire_unit`

## Requirements
- R1: After synchronous reset, in_ready is 1 and rf_we0, rf_we1, mem_we and ld_hit are all 0.
- R2: While in_ready is 1, a valid entry on lane 0 and a valid entry on lane 1 are both accepted at the same clock edge. Lane 0 is the older one.
- R3: A non-store entry accepted at edge k, with nothing older pending, drives its write lane at edge k+1. The write lane is rf_we0 for the oldest entry and rf_we1 for the second oldest, with rf_rd and rf_data taken from the entry.
- R4: Queued stores reach memory one per cycle, oldest first. mem_we, mem_addr and mem_data are registered, and they are asserted after an edge only if ld_req was 0 in the cycle before that edge.
- R5: When ld_req is 1 in a cycle, ld_hit and ld_data after the next edge give the youngest queued store whose address equals ld_addr.
- R6: A load address that matches no queued store gives ld_hit 0 and ld_data 0.
- R7: A store whose store queue has no free slot does not retire, and it is not visible to load searches. An older non-store in the same pair still retires.
- R8: in_ready is 0 while the completion buffer holds more than DEPTH-2 entries. Entries offered while in_ready is 0 are ignored.
- R9: Retirement never skips ahead. If the oldest entry cannot retire, the second one does not retire either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| in0_valid | input | 1 | lane 0 entry valid (older) |
| in0_is_store | input | 1 | lane 0 entry is a store |
| in0_rd | input | 4 | lane 0 destination register |
| in0_data | input | 16 | lane 0 result or store data |
| in0_addr | input | 16 | lane 0 store address |
| in1_valid | input | 1 | lane 1 entry valid (younger) |
| in1_is_store | input | 1 | lane 1 entry is a store |
| in1_rd | input | 4 | lane 1 destination register |
| in1_data | input | 16 | lane 1 result or store data |
| in1_addr | input | 16 | lane 1 store address |
| in_ready | output | 1 | room for a full pair of entries |
| rf_we0 | output | 1 | register write, oldest retiring slot |
| rf_rd0 | output | 4 | register index, oldest slot |
| rf_data0 | output | 16 | register data, oldest slot |
| rf_we1 | output | 1 | register write, second slot |
| rf_rd1 | output | 4 | register index, second slot |
| rf_data1 | output | 16 | register data, second slot |
| ld_req | input | 1 | load path wants the memory port and searches the queue |
| ld_addr | input | 16 | load address to search |
| ld_hit | output | 1 | search found a queued store |
| ld_data | output | 16 | data of the youngest matching store |
| mem_we | output | 1 | store write to data memory |
| mem_addr | output | 16 | memory write address |
| mem_data | output | 16 | memory write data |

## Verification
A corrupted completion-buffer pointer or count shows up within one or two cycles as a register write with the wrong index or data, as a write on the wrong lane, or as in_ready going low with too few entries held. Store-queue faults show up on the memory port, where stores arrive out of order or while ld_req is high. They also show up in searches, which return older data for a repeated address or report a store that never entered the queue. The bench therefore checks memory writes in sequence and repeats addresses across stores.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;
  parameter int CP_DW = 16;
  parameter int CP_AW = 16;
  parameter int CP_RW = 4;

  typedef struct packed {
    logic             is_store;
    logic [CP_RW-1:0] rd;
    logic [CP_DW-1:0] data;
    logic [CP_AW-1:0] addr;
  } cb_entry_t;
endpackage

// File: rtl/cmpl_buf.sv
// Circular completion buffer: two writes and up to two in-order reads per cycle.
// DEPTH must be a power of two.
module cmpl_buf
  import cmpl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr0,
  input  logic                       wr1,
  input  cb_entry_t                  wd0,
  input  cb_entry_t                  wd1,
  input  logic [1:0]                 rd_n,
  output cb_entry_t                  hd0,
  output cb_entry_t                  hd1,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       room2
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  cb_entry_t       slots [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (wr0) slots[wr_ptr] <= wd0;
    if (wr1) slots[wr_ptr + PW'(wr0)] <= wd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(wr0) + PW'(wr1);
      rd_ptr <= rd_ptr + PW'(rd_n);
      level  <= level + CW'(wr0) + CW'(wr1) - CW'(rd_n);
    end
  end

  assign hd0   = slots[rd_ptr];
  assign hd1   = slots[rd_ptr + PW'(1)];
  assign room2 = (level <= CW'(DEPTH-2));

  // R8
  cb_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  // R9
  cb_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    CW'(rd_n) <= level);
endmodule

// File: rtl/store_q.sv
// Store queue: two pushes per cycle, load-priority drain, youngest-match search.
// DEPTH must be a power of two.
module store_q
  import cmpl_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push0,
  input  logic             push1,
  input  logic [CP_AW-1:0] a0,
  input  logic [CP_DW-1:0] d0,
  input  logic [CP_AW-1:0] a1,
  input  logic [CP_DW-1:0] d1,
  output logic [1:0]       room,
  input  logic             ld_req,
  input  logic [CP_AW-1:0] ld_addr,
  output logic             ld_hit,
  output logic [CP_DW-1:0] ld_data,
  output logic             mem_we,
  output logic [CP_AW-1:0] mem_addr,
  output logic [CP_DW-1:0] mem_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [CP_AW-1:0] q_addr [DEPTH];
  logic [CP_DW-1:0] q_data [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    level;
  logic             drain;
  logic             s_hit;
  logic [CP_DW-1:0] s_data;
  logic [PW-1:0]    s_idx;

  assign drain = (level != '0) && !ld_req;
  assign room  = (level <= CW'(DEPTH-2)) ? 2'd2 :
                 (level == CW'(DEPTH-1)) ? 2'd1 : 2'd0;

  always_ff @(posedge clk) begin
    if (push0) begin
      q_addr[wr_ptr] <= a0;
      q_data[wr_ptr] <= d0;
    end
    if (push1) begin
      q_addr[wr_ptr + PW'(push0)] <= a1;
      q_data[wr_ptr + PW'(push0)] <= d1;
    end
  end

  // oldest to youngest; a later match overrides, so the youngest wins
  always_comb begin
    s_hit  = 1'b0;
    s_data = '0;
    s_idx  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      s_idx = rd_ptr + PW'(i);
      if ((CW'(i) < level) && (q_addr[s_idx] == ld_addr)) begin
        s_hit  = 1'b1;
        s_data = q_data[s_idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      ld_hit   <= 1'b0;
      ld_data  <= '0;
    end else begin
      wr_ptr   <= wr_ptr + PW'(push0) + PW'(push1);
      rd_ptr   <= rd_ptr + PW'(drain);
      level    <= level + CW'(push0) + CW'(push1) - CW'(drain);
      mem_we   <= drain;
      mem_addr <= drain ? q_addr[rd_ptr] : '0;
      mem_data <= drain ? q_data[rd_ptr] : '0;
      ld_hit   <= ld_req && s_hit;
      ld_data  <= (ld_req && s_hit) ? s_data : '0;
    end
  end

  // R7
  sq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  // R4
  mem_idle_port_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !$past(ld_req));
  // R5
  ld_hit_req_chk: assert property (@(posedge clk) disable iff (rst)
    ld_hit |-> $past(ld_req));
endmodule

// File: rtl/retire_sel.sv
// Decides which of the two oldest entries retire this cycle, strictly in order.
module retire_sel
  import cmpl_pkg::*;
(
  input  cb_entry_t  hd0,
  input  cb_entry_t  hd1,
  input  logic [1:0] avail,
  input  logic [1:0] sq_room,
  output logic       ok0,
  output logic       ok1
);
  logic [1:0] need1;

  assign need1 = 2'd1 + 2'(hd0.is_store);
  assign ok0   = (avail != 2'd0) && (!hd0.is_store || sq_room != 2'd0);
  assign ok1   = ok0 && (avail == 2'd2) && (!hd1.is_store || sq_room >= need1);
endmodule

// File: rtl/cmpl_retire_unit.sv
module cmpl_retire_unit
  import cmpl_pkg::*;
#(
  parameter int CB_DEPTH = 8,
  parameter int SQ_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in0_valid,
  input  logic             in0_is_store,
  input  logic [CP_RW-1:0] in0_rd,
  input  logic [CP_DW-1:0] in0_data,
  input  logic [CP_AW-1:0] in0_addr,
  input  logic             in1_valid,
  input  logic             in1_is_store,
  input  logic [CP_RW-1:0] in1_rd,
  input  logic [CP_DW-1:0] in1_data,
  input  logic [CP_AW-1:0] in1_addr,
  output logic             in_ready,
  output logic             rf_we0,
  output logic [CP_RW-1:0] rf_rd0,
  output logic [CP_DW-1:0] rf_data0,
  output logic             rf_we1,
  output logic [CP_RW-1:0] rf_rd1,
  output logic [CP_DW-1:0] rf_data1,
  input  logic             ld_req,
  input  logic [CP_AW-1:0] ld_addr,
  output logic             ld_hit,
  output logic [CP_DW-1:0] ld_data,
  output logic             mem_we,
  output logic [CP_AW-1:0] mem_addr,
  output logic [CP_DW-1:0] mem_data
);
  localparam int CBW = $clog2(CB_DEPTH+1);

  cb_entry_t      wd0, wd1, hd0, hd1;
  logic [CBW-1:0] cb_level;
  logic [1:0]     avail, sq_room, rd_n;
  logic           wr0, wr1, ok0, ok1;

  assign wd0 = '{is_store: in0_is_store, rd: in0_rd, data: in0_data, addr: in0_addr};
  assign wd1 = '{is_store: in1_is_store, rd: in1_rd, data: in1_data, addr: in1_addr};
  assign wr0 = in_ready && in0_valid;
  assign wr1 = in_ready && in1_valid;

  cmpl_buf #(.DEPTH(CB_DEPTH)) u_cb (
    .clk(clk), .rst(rst), .wr0(wr0), .wr1(wr1), .wd0(wd0), .wd1(wd1),
    .rd_n(rd_n), .hd0(hd0), .hd1(hd1), .level(cb_level), .room2(in_ready)
  );

  assign avail = (cb_level >= CBW'(2)) ? 2'd2 : 2'(cb_level);

  retire_sel u_sel (
    .hd0(hd0), .hd1(hd1), .avail(avail), .sq_room(sq_room), .ok0(ok0), .ok1(ok1)
  );

  assign rd_n = 2'(ok0) + 2'(ok1);

  store_q #(.DEPTH(SQ_DEPTH)) u_sq (
    .clk(clk), .rst(rst),
    .push0(ok0 && hd0.is_store), .push1(ok1 && hd1.is_store),
    .a0(hd0.addr), .d0(hd0.data), .a1(hd1.addr), .d1(hd1.data),
    .room(sq_room), .ld_req(ld_req), .ld_addr(ld_addr),
    .ld_hit(ld_hit), .ld_data(ld_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we0   <= 1'b0;
      rf_rd0   <= '0;
      rf_data0 <= '0;
      rf_we1   <= 1'b0;
      rf_rd1   <= '0;
      rf_data1 <= '0;
    end else begin
      rf_we0   <= ok0 && !hd0.is_store;
      rf_rd0   <= hd0.rd;
      rf_data0 <= hd0.data;
      rf_we1   <= ok1 && !hd1.is_store;
      rf_rd1   <= hd1.rd;
      rf_data1 <= hd1.data;
    end
  end

  // R9
  lane1_order_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we1 |-> ($past(cb_level) >= CBW'(2)));
endmodule

// File: tb/cmpl_retire_unit_tb.sv
module cmpl_retire_unit_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        in0_valid = 0, in0_is_store = 0, in1_valid = 0, in1_is_store = 0;
  logic [3:0]  in0_rd = 0, in1_rd = 0;
  logic [15:0] in0_data = 0, in0_addr = 0, in1_data = 0, in1_addr = 0;
  logic        ld_req = 0;
  logic [15:0] ld_addr = 0;
  logic        in_ready, rf_we0, rf_we1, ld_hit, mem_we;
  logic [3:0]  rf_rd0, rf_rd1;
  logic [15:0] rf_data0, rf_data1, ld_data, mem_addr, mem_data;
  int          checks = 0, errors = 0;

  always #4 clk = ~clk;

  cmpl_retire_unit u_dut (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put0(logic st, logic [3:0] rd, logic [15:0] d, logic [15:0] a);
    in0_valid = 1; in0_is_store = st; in0_rd = rd; in0_data = d; in0_addr = a;
  endtask
  task automatic put1(logic st, logic [3:0] rd, logic [15:0] d, logic [15:0] a);
    in1_valid = 1; in1_is_store = st; in1_rd = rd; in1_data = d; in1_addr = a;
  endtask
  task automatic idle_in();
    in0_valid = 0; in1_valid = 0;
  endtask

  task automatic t_reset();
    chk("R1 in_ready", in_ready, 1);
    chk("R1 rf_we0", rf_we0, 0);
    chk("R1 rf_we1", rf_we1, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 ld_hit", ld_hit, 0);
  endtask

  task automatic t_alu_pair();
    put0(0, 4'd1, 16'h00A1, 0); put1(0, 4'd2, 16'h00B2, 0);
    tick(); idle_in();
    tick();
    chk("R2 rf_we0", rf_we0, 1); chk("R3 rf_rd0", rf_rd0, 1); chk("R3 rf_data0", rf_data0, 16'h00A1);
    chk("R2 rf_we1", rf_we1, 1); chk("R3 rf_rd1", rf_rd1, 2); chk("R3 rf_data1", rf_data1, 16'h00B2);
    put0(0, 4'd7, 16'h0777, 0);
    tick(); idle_in();
    tick();
    chk("R3 single rf_we0", rf_we0, 1); chk("R3 single rf_rd0", rf_rd0, 7);
    chk("R3 single rf_we1", rf_we1, 0);
  endtask

  task automatic t_store_drain();
    put0(1, 0, 16'h1111, 16'h0010); put1(0, 4'd3, 16'h0333, 0);
    tick(); idle_in();
    tick();
    chk("R3 store lane0 no rf", rf_we0, 0);
    chk("R3 lane1 rf_we1", rf_we1, 1); chk("R3 lane1 rd", rf_rd1, 3);
    tick();
    chk("R4 mem_we", mem_we, 1); chk("R4 mem_addr", mem_addr, 16'h0010);
    chk("R4 mem_data", mem_data, 16'h1111);
    tick();
    chk("R4 mem idle", mem_we, 0);
  endtask

  task automatic t_load_search();
    ld_req = 1; ld_addr = 16'h0040;
    put0(1, 0, 16'h00A1, 16'h0020); put1(1, 0, 16'h00B2, 16'h0030);
    tick(); idle_in();
    put0(1, 0, 16'h00C3, 16'h0020);
    tick(); idle_in();
    tick(); tick();
    chk("R4 held by load", mem_we, 0);
    chk("R6 miss hit", ld_hit, 0); chk("R6 miss data", ld_data, 0);
    ld_addr = 16'h0020;
    tick();
    chk("R5 youngest hit", ld_hit, 1); chk("R5 youngest data", ld_data, 16'h00C3);
    ld_addr = 16'h0030;
    tick();
    chk("R5 hit 0x30", ld_hit, 1); chk("R5 data 0x30", ld_data, 16'h00B2);
  endtask

  task automatic t_sq_full_stall();
    logic [15:0] ea [3];
    logic [15:0] ed [3];
    ea = '{16'h0020, 16'h0050, 16'h0060};
    ed = '{16'h00C3, 16'h00D4, 16'h00E5};
    put0(1, 0, 16'h00D4, 16'h0050);
    tick(); idle_in();
    tick();
    put0(0, 4'd4, 16'h0044, 0); put1(1, 0, 16'h00E5, 16'h0060);
    tick(); idle_in();
    put0(0, 4'd5, 16'h0055, 0);
    tick(); idle_in();
    chk("R7 older alu retires", rf_we0, 1); chk("R7 older alu rd", rf_rd0, 4);
    chk("R7 store stalls lane1", rf_we1, 0);
    ld_addr = 16'h0060;
    tick();
    chk("R9 no skip we0", rf_we0, 0); chk("R9 no skip we1", rf_we1, 0);
    chk("R7 stalled store not searchable", ld_hit, 0);
    ld_req = 0;
    tick();
    chk("R4 first drain we", mem_we, 1); chk("R4 first drain addr", mem_addr, 16'h0020);
    chk("R4 first drain data", mem_data, 16'h00A1); chk("R9 still waiting", rf_we1, 0);
    tick();
    chk("R9 younger alu after store", rf_we1, 1); chk("R9 younger rd", rf_rd1, 5);
    chk("R9 store lane0", rf_we0, 0);
    chk("R4 second drain addr", mem_addr, 16'h0030); chk("R4 second drain data", mem_data, 16'h00B2);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R4 order addr", mem_addr, ea[k]); chk("R4 order data", mem_data, ed[k]);
    end
    tick();
    chk("R4 queue empty", mem_we, 0);
  endtask

  task automatic t_cb_full();
    int writes = 0, bad = 0;
    ld_req = 1; ld_addr = 16'hFFFF;
    for (int p = 0; p < 6; p++) begin
      put0(1, 0, 16'(p * 2), 16'(16'h0080 + p * 2));
      put1(1, 0, 16'(p * 2 + 1), 16'(16'h0081 + p * 2));
      tick();
      if (p == 4) chk("R8 ready at DEPTH-2", in_ready, 1);
    end
    idle_in();
    chk("R8 not ready when full", in_ready, 0);
    put0(1, 0, 16'h00EE, 16'h0077); put1(1, 0, 16'h00EF, 16'h0077);
    tick(); tick(); idle_in();
    chk("R8 stays not ready", in_ready, 0);
    ld_req = 0;
    for (int c = 0; c < 30; c++) begin
      tick();
      if (mem_we) begin
        writes++;
        if (mem_addr == 16'h0077) bad++;
      end
    end
    chk("R8 offered-while-full ignored", bad, 0);
    chk("R8 all stores reach memory", writes, 12);
    chk("R8 ready after drain", in_ready, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    t_reset();
    t_alu_pair();
    t_store_drain();
    t_load_search();
    t_sq_full_stall();
    t_cb_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule